// File: doc/BRIEF.md
# Store-to-Load Forwarding Decision Unit

This block decides the fate of one load at a time. It compares the load's byte range with the older stores in a small circular store queue. Each load is either served with store data, held back (stall), or sent on to the cache. The load supplies:

- its address;
- a size code;
- a flag that marks it as a locked (load-linked) load;
- the queue slot of the youngest store older than itself;
- how many older stores to consider.

The store queue presents, for every slot, a valid bit, an address, a size code, a 64-bit data word and a written-back flag.

The unit walks the considered stores from the youngest toward the oldest, and the first valid store that overlaps the load settles the outcome. An ordinary load that a store fully covers takes byte-aligned data from that store. A locked load never takes forwarded data. Any overlap with a pending store stalls a locked load, so the locked access always reaches the cache. A store that has already been written back never causes a stall.

Requests enter on a valid/ready pair. The result leaves through a one-entry output register with its own valid/ready pair:

- `ld_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `res_valid` is high and `res_ready` is low, the result holds steady and no new load is taken.

The queue depth must be a power of two.

Top module: `ldfwd_unit`

## Requirements
- R1: After reset `res_valid` is 0 and `ld_ready` is 1.
- R2: A load taken on a clock edge (`ld_valid` and `ld_ready` high) has its result in `res_valid`/`res_outcome`/`res_data` from that edge on. `ld_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, the outputs hold their values.
- R3: An ordinary load fully covered by the deciding store gets outcome 1 (forward). Full cover means store start ≤ load start and store end ≥ load end. The forwarded data is the store data shifted right by 8·(load address − store address) bits, keeping the low bytes given by the load size; all higher bits are 0.
- R4: A locked load never gets outcome 1. If the deciding store is not written back, the locked load gets outcome 2 (stall), even under full cover.
- R5: An ordinary load that overlaps the deciding store without being fully covered by it gets outcome 2 if that store is not written back. Any result other than forward carries `res_data` of 0.
- R6: If the deciding store is written back, the outcome is 0 (cache). The one exception is an ordinary load it fully covers, which still gets outcome 1.
- R7: If no considered store is both valid and overlapping, the outcome is 0. Slots with the valid bit low, and slots outside the older window, have no effect.
- R8: The considered slots are `ld_youngest`, `ld_youngest`−1, … (modulo the depth), `ld_older` of them in all. The first valid overlapping one in that order is the deciding store.
- R9: Size code c (0..3) means 2^c bytes (1, 2, 4, 8). Ranges are half-open. A load [La, La+Ls) overlaps a store [Sa, Sa+Ss) exactly when La < Sa+Ss and La+Ls > Sa, computed without address wrap. Touching ranges do not overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Unit can take a load this cycle |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code (2^code bytes) |
| ld_locked | input | 1 | Load is a locked (load-linked) load |
| ld_youngest | input | log2(SQ_DEPTH) | Slot of the youngest older store |
| ld_older | input | log2(SQ_DEPTH)+1 | Number of older stores to scan |
| sq_valid | input | SQ_DEPTH | Per-slot valid bits |
| sq_addr | input | SQ_DEPTH*AW | Per-slot store address, slot i at bits [i*AW +: AW] |
| sq_size | input | SQ_DEPTH*2 | Per-slot size code, slot i at [i*2 +: 2] |
| sq_data | input | SQ_DEPTH*64 | Per-slot store data, slot i at [i*64 +: 64], byte 0 lowest |
| sq_wb | input | SQ_DEPTH | Per-slot written-back flags |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_outcome | output | 2 | 0 cache, 1 forward, 2 stall |
| res_data | output | 64 | Forwarded data, 0 unless outcome is 1 |

## Verification
Two of the block's functions meet in the same cycle: the per-slot range classification and the age-ordered pick.

- A younger store can overlap the load only partly while an older store covers it fully, or the reverse. Only the pick order tells whether the result is forward or stall.
- The sweeps hold four stores of different sizes, one of them written back. They step the youngest slot and the window length over every value against every load address, size and locked flag.
- Each result is judged against an arithmetic model that walks the same age order.

A second collision is back-pressure arriving together with a new request. It is judged by checking that the held result stays put and that the waiting load is taken on the first edge after release.

// File: rtl/ldfwd_pkg.sv
package ldfwd_pkg;
  localparam int DATA_W = 64;
  localparam int SIZE_W = 2;

  typedef enum logic [1:0] {
    OUT_CACHE = 2'd0,
    OUT_FWD   = 2'd1,
    OUT_STALL = 2'd2
  } outcome_e;

  function automatic logic [3:0] size_bytes(input logic [SIZE_W-1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/ldfwd_span_check.sv
module ldfwd_span_check
  import ldfwd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]     ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [AW-1:0]     st_addr,
  input  logic [SIZE_W-1:0] st_size,
  output logic              overlap,
  output logic              covers
);
  localparam int EW = AW + 1;

  logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;

  always_comb begin
    ld_lo   = {1'b0, ld_addr};
    st_lo   = {1'b0, st_addr};
    ld_hi   = ld_lo + EW'(size_bytes(ld_size));
    st_hi   = st_lo + EW'(size_bytes(st_size));
    overlap = (ld_lo < st_hi) && (ld_hi > st_lo);
    covers  = (st_lo <= ld_lo) && (st_hi >= ld_hi);
  end
endmodule

// File: rtl/ldfwd_scan.sv
module ldfwd_scan #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] hit,
  input  logic [IW-1:0]    youngest,
  input  logic [IW:0]      older_cnt,
  output logic             found,
  output logic [IW-1:0]    pick_idx,
  output logic [DEPTH-1:0] pick_oh
);
  always_comb begin
    logic [IW-1:0] idx;
    found    = 1'b0;
    pick_idx = '0;
    pick_oh  = '0;
    idx      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = youngest - IW'(k);
      if (!found && ((IW+1)'(k) < older_cnt) && hit[idx]) begin
        found         = 1'b1;
        pick_idx      = idx;
        pick_oh[idx]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldfwd_align.sv
module ldfwd_align
  import ldfwd_pkg::*;
(
  input  logic [DATA_W-1:0] st_data,
  input  logic [2:0]        byte_shift,
  input  logic [SIZE_W-1:0] ld_size,
  output logic [DATA_W-1:0] ld_data
);
  logic [DATA_W-1:0] shifted, keep;

  always_comb begin
    shifted = st_data >> {byte_shift, 3'b000};
    unique case (ld_size)
      2'd0:    keep = 64'h0000_0000_0000_00FF;
      2'd1:    keep = 64'h0000_0000_0000_FFFF;
      2'd2:    keep = 64'h0000_0000_FFFF_FFFF;
      default: keep = '1;
    endcase
    ld_data = shifted & keep;
  end
endmodule

// File: rtl/ldfwd_unit.sv
module ldfwd_unit
  import ldfwd_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int AW = 16,
  localparam int IW = $clog2(SQ_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  output logic                     ld_ready,
  input  logic [AW-1:0]            ld_addr,
  input  logic [1:0]               ld_size,
  input  logic                     ld_locked,
  input  logic [IW-1:0]            ld_youngest,
  input  logic [IW:0]              ld_older,
  input  logic [SQ_DEPTH-1:0]      sq_valid,
  input  logic [SQ_DEPTH*AW-1:0]   sq_addr,
  input  logic [SQ_DEPTH*2-1:0]    sq_size,
  input  logic [SQ_DEPTH*64-1:0]   sq_data,
  input  logic [SQ_DEPTH-1:0]      sq_wb,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [1:0]               res_outcome,
  output logic [63:0]              res_data
);
  logic [SQ_DEPTH-1:0] ovl, cov, hit;
  logic                found;
  logic [IW-1:0]       pick_idx;
  logic [SQ_DEPTH-1:0] pick_oh;

  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_span
    ldfwd_span_check #(.AW(AW)) u_span (
      .ld_addr (ld_addr),
      .ld_size (ld_size),
      .st_addr (sq_addr[i*AW +: AW]),
      .st_size (sq_size[i*2 +: 2]),
      .overlap (ovl[i]),
      .covers  (cov[i])
    );
    assign hit[i] = sq_valid[i] && ovl[i];
  end

  ldfwd_scan #(.DEPTH(SQ_DEPTH)) u_scan (
    .hit       (hit),
    .youngest  (ld_youngest),
    .older_cnt (ld_older),
    .found     (found),
    .pick_idx  (pick_idx),
    .pick_oh   (pick_oh)
  );

  logic          sel_cover, sel_wb;
  logic [AW-1:0] sel_addr, addr_diff;
  logic [63:0]   aligned;

  assign sel_cover = cov[pick_idx];
  assign sel_wb    = sq_wb[pick_idx];
  assign sel_addr  = sq_addr[pick_idx*AW +: AW];
  assign addr_diff = ld_addr - sel_addr;

  ldfwd_align u_align (
    .st_data    (sq_data[pick_idx*64 +: 64]),
    .byte_shift (addr_diff[2:0]),
    .ld_size    (ld_size),
    .ld_data    (aligned)
  );

  outcome_e verdict;
  always_comb begin
    if (!found)                       verdict = OUT_CACHE;
    else if (!ld_locked && sel_cover) verdict = OUT_FWD;
    else if (sel_wb)                  verdict = OUT_CACHE;
    else                              verdict = OUT_STALL;
  end

  logic accept;
  assign ld_ready = !res_valid || res_ready;
  assign accept   = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_outcome <= OUT_CACHE;
      res_data    <= '0;
    end else if (accept) begin
      res_valid   <= 1'b1;
      res_outcome <= verdict;
      res_data    <= (verdict == OUT_FWD) ? aligned : '0;
    end else if (res_ready) begin
      res_valid   <= 1'b0;
    end
  end

  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh)); // R8
  AST_LOCK_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ld_locked |=> res_outcome != OUT_FWD); // R4
  AST_PARTIAL_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && found && !cov[pick_idx] |=> res_outcome != OUT_FWD); // R5
  AST_MISS_TO_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !found |=> res_outcome == OUT_CACHE); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_outcome) && $stable(res_data)); // R2
  AST_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_outcome != OUT_FWD |-> res_data == '0); // R5
endmodule

// File: tb/ldfwd_unit_test.sv
`timescale 1ns/1ps
module ldfwd_unit_test;
  localparam int N  = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           ld_valid = 1'b0, ld_locked = 1'b0, res_ready = 1'b1;
  logic [AW-1:0]  ld_addr = '0;
  logic [1:0]     ld_size = '0;
  logic [1:0]     ld_youngest = '0;
  logic [2:0]     ld_older = '0;
  logic           ld_ready, res_valid;
  logic [1:0]     res_outcome;
  logic [63:0]    res_data;

  logic           bv [N];
  logic [AW-1:0]  ba [N];
  logic [1:0]     bc [N];
  logic           bw [N];
  logic [63:0]    bd [N];

  logic [N-1:0]    sq_valid, sq_wb;
  logic [N*AW-1:0] sq_addr;
  logic [N*2-1:0]  sq_size;
  logic [N*64-1:0] sq_data;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      sq_valid[i]          = bv[i];
      sq_wb[i]             = bw[i];
      sq_addr[i*AW +: AW]  = ba[i];
      sq_size[i*2 +: 2]    = bc[i];
      sq_data[i*64 +: 64]  = bd[i];
    end
  end

  ldfwd_unit #(.SQ_DEPTH(N), .AW(AW)) uut (
    .clk, .rst_n, .ld_valid, .ld_ready, .ld_addr, .ld_size, .ld_locked,
    .ld_youngest, .ld_older, .sq_valid, .sq_addr, .sq_size, .sq_data,
    .sq_wb, .res_valid, .res_ready, .res_outcome, .res_data
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model(input int la, input int lc, input int lk,
                       output int eo, output logic [63:0] ed, output string tag);
    int ls = 1 << lc;
    eo = 0; ed = '0; tag = "R7";
    for (int k = 0; k < int'(ld_older); k++) begin
      int idx = (int'(ld_youngest) - k) & (N - 1);
      int sa = int'(ba[idx]);
      int ss = 1 << int'(bc[idx]);
      if (bv[idx] && la < sa + ss && la + ls > sa) begin
        if (lk == 0 && sa <= la && sa + ss >= la + ls) begin
          eo = 1; tag = "R3";
          ed = bd[idx] >> (8 * (la - sa));
          if (ls < 8) ed = ed & ((64'd1 << (8 * ls)) - 64'd1);
        end else if (bw[idx]) begin
          eo = 0; tag = "R6";
        end else begin
          eo = 2; tag = (lk != 0) ? "R4" : "R5";
        end
        break;
      end
    end
  endtask

  task automatic do_load(input int la, input int lc, input int lk, input string pre);
    int eo; logic [63:0] ed; string tag;
    @(negedge clk);
    ld_addr = AW'(la); ld_size = 2'(lc); ld_locked = lk[0]; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    model(la, lc, lk, eo, ed, tag);
    check({pre, tag}, {res_valid, 1'b0, res_outcome, res_data[59:0]},
          {1'b1, 1'b0, 2'(eo), ed[59:0]});
    check({pre, tag, " data"}, res_data, ed);
  endtask

  task automatic fill(input int i, input int a, input int c, input int w, input int v);
    bv[i] = v[0]; ba[i] = AW'(a); bc[i] = 2'(c); bw[i] = w[0];
    for (int b = 0; b < 8; b++) bd[i][b*8 +: 8] = 8'(16 * (i + 1) + b + 1);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) fill(i, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 res_valid", 64'(res_valid), 64'd0);
    check("R1 ld_ready", 64'(ld_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_valid after release", 64'(res_valid), 64'd0);

    // single store sweep: slot 2 at address 6
    ld_youngest = 2'd3; ld_older = 3'd4;
    for (int sc = 0; sc < 4; sc++)
      for (int w = 0; w < 2; w++) begin
        fill(2, 6, sc, w, 1);
        for (int la = 0; la < 16; la++)
          for (int lc = 0; lc < 4; lc++)
            for (int lk = 0; lk < 2; lk++)
              do_load(la, lc, lk, "sweep1 ");
      end

    // R9 touching ranges do not overlap
    for (int i = 0; i < N; i++) fill(i, 0, 0, 0, 0);
    fill(0, 0, 3, 0, 1);
    ld_youngest = 2'd0; ld_older = 3'd1;
    @(negedge clk);
    ld_addr = 8'd8; ld_size = 2'd0; ld_locked = 1'b1; ld_valid = 1'b1;
    @(negedge clk); ld_valid = 1'b0;
    check("R9 adjacent", 64'(res_outcome), 64'd0);
    @(negedge clk);
    ld_addr = 8'd7; ld_size = 2'd1; ld_locked = 1'b0; ld_valid = 1'b1;
    @(negedge clk); ld_valid = 1'b0;
    check("R9 straddle", 64'(res_outcome), 64'd2);

    // R2 back-pressure with a waiting load
    @(negedge clk);
    res_ready = 1'b0;
    ld_addr = 8'd2; ld_size = 2'd1; ld_locked = 1'b0; ld_valid = 1'b1;
    @(negedge clk);
    ld_addr = 8'd20;
    check("R2 held outcome", 64'(res_outcome), 64'd1);
    check("R2 held data", res_data, (bd[0] >> 16) & 64'hFFFF);
    check("R2 ready low", 64'(ld_ready), 64'd0);
    @(negedge clk);
    check("R2 still held", {res_valid, res_data}, {1'b1, (bd[0] >> 16) & 64'hFFFF});
    res_ready = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R2 next load", {res_valid, res_outcome, res_data}, {1'b1, 2'd0, 64'd0});
    @(negedge clk);
    check("R2 drained", 64'(res_valid), 64'd0);

    // R8 ordering sweep: four stores, slot 1 written back
    fill(0, 2, 0, 0, 1);
    fill(1, 5, 1, 1, 1);
    fill(2, 4, 2, 0, 1);
    fill(3, 6, 3, 0, 1);
    for (int y = 0; y < N; y++)
      for (int c = 0; c <= N; c++) begin
        ld_youngest = 2'(y); ld_older = 3'(c);
        for (int la = 0; la < 16; la++)
          for (int lc = 0; lc < 4; lc++)
            for (int lk = 0; lk < 2; lk++)
              do_load(la, lc, lk, "R8 order ");
      end

    // R7 invalid slots ignored
    for (int i = 0; i < N; i++) bv[i] = 1'b0;
    ld_youngest = 2'd3; ld_older = 3'd4;
    for (int la = 0; la < 16; la++) do_load(la, 3, la & 1, "R7 invalid ");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule